// File: doc/BRIEF.md
# SMBus Byte-Command Register Slave

This block is a target on a two-wire SMBus segment. It holds a small bank of 8-bit registers and exposes them through two transactions only. In a write byte the controller sends the slave address with the write bit, a command byte that selects a register, and one data byte. In a read byte the controller sends the address with the write bit and the command byte, then a repeated start, then the address with the read bit, and the slave returns the selected register. The block samples SCL and SDA against its own clock, recognises start and stop conditions, shifts bytes in and out, and drives SDA only as an open-drain low.

A write is staged while it is received and reaches the register bank only on the stop that closes a complete, well-formed write byte. Any deviation abandons the transaction and leaves every register untouched. Deviations include an address that does not match, a command naming a missing or disabled register, a start or stop inside a byte, and an extra byte after the data byte. The surrounding logic can block individual registers through an enable vector. A blocked register can be neither read nor written.

Top module: `smbus_reg_slave`

## Requirements
- R1: After reset every register reads 0x00 on `regs_o` and `sda_oe_o` is 0 (SDA released).
- R2: A write byte (start, address byte {SLV_ADDR,0}, command byte, data byte, stop) gets an ACK (SDA low on the ninth clock) for each of its three bytes, and the register numbered by the command byte takes the data byte when the stop arrives. Registers change at no other time.
- R3: An address byte whose upper seven bits differ from SLV_ADDR gets no ACK and changes nothing. The same holds for an address byte with bit 0 = 1 (read) as the first byte after a start, or one with bit 0 = 0 after the repeated start.
- R4: A read byte (start, {SLV_ADDR,0}, command, repeated start, {SLV_ADDR,1}) ACKs all three bytes. The slave then sends the selected register most significant bit first. The controller NACKs and stops, and no register changes.
- R5: A command byte with a value of NREG or more gets no ACK, and the transaction leaves all registers unchanged.
- R6: A command byte naming register k while bit k of `reg_en_i` is 0 gets no ACK, so register k can be neither written nor read. Other registers stay reachable.
- R7: A start or stop condition arriving after the second bit of a byte has been clocked aborts the transaction with no register update. The slave then accepts the next valid transaction.
- R8: A byte clocked after the acknowledged data byte of a write gets no ACK, and the staged write is discarded at the stop.
- R9: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversampling SCL and SDA |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired bus value) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_en_i | input | NREG | Per-register access enable |
| regs_o | output | 8*NREG | Register bank contents, register k in bits [8k+7:8k] |

## Verification
The bench builds the block with NREG = 6 and SLV_ADDR = 7'h2C. This gives a 3-bit index in which the command values 6 and 7 fit the index width but are outside the bank, which exercises the range check separately from the width. Small NREG lets every register be written and read back with two patterns. The full 128-value address space is swept for the ACK decision. A blocked register in the middle of the bank, aborts at bit positions inside a byte, and a trailing extra byte are all reached within a short run.

// File: rtl/smbrs_pkg.sv
package smbrs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK,
    PH_TX,
    PH_MACK,
    PH_HOLD
  } phase_t;

  typedef enum logic [1:0] {
    RL_ADDR_W,
    RL_CMD,
    RL_DATA,
    RL_ADDR_R
  } role_t;

  // Address byte: seven address bits above the direction bit (1 = read).
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a,
                                    input logic want_rd);
    return (b[7:1] == a) && (b[0] == want_rd);
  endfunction

  // A repeated start is only taken while the data byte has not yet begun:
  // the rising SCL before the restart may already have clocked one bit.
  function automatic logic restart_window(input logic [3:0] bits_seen);
    return bits_seen <= 4'd1;
  endfunction

  // At most one SCL rise (the one leading into the stop) may follow the data ACK.
  function automatic logic tail_clean(input logic [1:0] rises);
    return rises <= 2'd1;
  endfunction

endpackage

// File: rtl/smbrs_line_cond.sv
module smbrs_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_hi,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m, scl_s, scl_p;
  logic sda_m, sda_s, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_p} <= 3'b111;
      {sda_m, sda_s, sda_p} <= 3'b111;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign scl_hi   = scl_s;
  assign sda_lvl  = sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smbrs_proto.sv
module smbrs_proto
  import smbrs_pkg::*;
#(
  parameter int          NREG     = 6,
  parameter logic [6:0]  SLV_ADDR = 7'h2C,
  localparam int         IDXW     = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_hi,
  input  logic            sda_lvl,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_ev,
  input  logic            stop_ev,
  input  logic [NREG-1:0] reg_en_i,
  input  logic [7:0]      rd_data,
  output logic [IDXW-1:0] sel_idx,
  output logic            wr_en,
  output logic [7:0]      wr_data,
  output logic            sda_oe
);
  phase_t     ph;
  role_t      role;
  logic [6:0] sh;
  logic [3:0] cnt;
  logic       drv, ack_on, wr_ok;
  logic [1:0] hold_rise;
  logic [6:0] tx_q;
  logic [IDXW-1:0] cmd_q;
  logic [7:0] dat_q;

  // Named internal events
  logic [7:0] rx_byte;
  logic       byte_done, addr_ok, cmd_ok, accept, restart_ev, abort_ev, commit;

  assign rx_byte    = {sh, sda_lvl};
  assign byte_done  = (ph == PH_RX) && scl_rise && (cnt == 4'd7);
  assign addr_ok    = addr_hit(rx_byte, SLV_ADDR, role == RL_ADDR_R);
  assign restart_ev = start_ev && (ph == PH_RX) && (role == RL_DATA) && restart_window(cnt);
  assign abort_ev   = (start_ev && (ph != PH_IDLE) && !restart_ev) ||
                      (stop_ev && (ph != PH_IDLE) && (ph != PH_HOLD));
  assign commit     = stop_ev && (ph == PH_HOLD) && wr_ok && tail_clean(hold_rise);

  always_comb begin
    cmd_ok = 1'b0;
    for (int i = 0; i < NREG; i++)
      if (rx_byte == 8'(i)) cmd_ok = reg_en_i[i];
  end

  always_comb begin
    unique case (role)
      RL_CMD:  accept = cmd_ok;
      RL_DATA: accept = 1'b1;
      default: accept = addr_ok;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; role <= RL_ADDR_W; sh <= '0; cnt <= '0;
      drv <= 1'b0; ack_on <= 1'b0; wr_ok <= 1'b0; hold_rise <= '0;
      tx_q <= '0; cmd_q <= '0; dat_q <= '0;
    end else if (stop_ev) begin
      ph <= PH_IDLE; drv <= 1'b0; wr_ok <= 1'b0;
    end else if (start_ev) begin
      if (ph == PH_IDLE) begin
        ph <= PH_RX; role <= RL_ADDR_W; cnt <= '0; wr_ok <= 1'b0;
      end else if (restart_ev) begin
        role <= RL_ADDR_R; cnt <= '0;
      end else begin
        ph <= PH_IDLE; drv <= 1'b0; wr_ok <= 1'b0;
      end
    end else begin
      unique case (ph)
        PH_RX: if (scl_rise) begin
          sh <= rx_byte[6:0];
          if (cnt == 4'd7) begin
            cnt <= '0;
            if (accept) begin
              ph <= PH_ACK; ack_on <= 1'b0;
              if (role == RL_CMD)  cmd_q <= rx_byte[IDXW-1:0];
              if (role == RL_DATA) begin dat_q <= rx_byte; wr_ok <= 1'b1; end
            end else begin
              ph <= PH_IDLE;
            end
          end else begin
            cnt <= cnt + 4'd1;
          end
        end
        PH_ACK: if (scl_fall) begin
          if (!ack_on) begin
            drv <= 1'b1; ack_on <= 1'b1;
          end else begin
            ack_on <= 1'b0;
            unique case (role)
              RL_ADDR_W: begin ph <= PH_RX; role <= RL_CMD;  drv <= 1'b0; end
              RL_CMD:    begin ph <= PH_RX; role <= RL_DATA; drv <= 1'b0; end
              RL_DATA:   begin ph <= PH_HOLD; hold_rise <= '0; drv <= 1'b0; end
              default:   begin
                ph <= PH_TX; tx_q <= rd_data[6:0]; drv <= ~rd_data[7]; cnt <= 4'd1;
              end
            endcase
          end
        end
        PH_TX: if (scl_fall) begin
          if (cnt == 4'd8) begin
            drv <= 1'b0; ph <= PH_MACK;
          end else begin
            drv <= ~tx_q[6]; tx_q <= {tx_q[5:0], 1'b0}; cnt <= cnt + 4'd1;
          end
        end
        PH_MACK: if (scl_rise) begin ph <= PH_HOLD; hold_rise <= '0; end
        PH_HOLD: if (scl_rise && hold_rise != 2'd3) hold_rise <= hold_rise + 2'd1;
        default: ;
      endcase
    end
  end

  assign sel_idx = cmd_q;
  assign wr_en   = commit;
  assign wr_data = dat_q;
  assign sda_oe  = drv;

  // R9: the pull-down only moves while SCL is low
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv) |-> !$past(scl_hi));

  // R3: rejected address byte leaves the bus released and the slave idle
  a_r3_addr_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (role == RL_ADDR_W || role == RL_ADDR_R) && !addr_ok)
      |=> (ph == PH_IDLE) && !drv);

  // R5 and R6: rejected command byte is not acknowledged
  a_r5_bad_cmd_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (role == RL_CMD) && !cmd_ok) |=> (ph == PH_IDLE) && !drv);

  // R7: an abort never coincides with a commit and ends in idle
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |-> !wr_en ##1 (ph == PH_IDLE));
endmodule

// File: rtl/smbrs_regfile.sv
module smbrs_regfile #(
  parameter int  NREG = 6,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    sel_idx,
  input  logic [7:0]         wr_data,
  input  logic [NREG-1:0]    reg_en_i,
  output logic [7:0]         rd_data,
  output logic [8*NREG-1:0]  regs_o
);
  logic [7:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      q[g] <= 8'h00;
      else if (wr_en && sel_idx == IDXW'(g))           q[g] <= wr_data;
    end
    assign regs_o[8*g +: 8] = q[g];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (sel_idx == IDXW'(i)) rd_data = q[i];
  end

  // R2: bank contents only move on a commit
  a_r2_stable_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o));

  // R6: a commit only ever targets an implemented, enabled register
  a_r6_commit_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(sel_idx) < NREG) && reg_en_i[sel_idx]);
endmodule

// File: rtl/smbus_reg_slave.sv
module smbus_reg_slave #(
  parameter int          NREG     = 6,
  parameter logic [6:0]  SLV_ADDR = 7'h2C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [NREG-1:0]    reg_en_i,
  output logic [8*NREG-1:0]  regs_o
);
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  logic scl_hi, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_en;
  logic [IDXW-1:0] sel_idx;
  logic [7:0] wr_data, rd_data;

  smbrs_line_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_hi(scl_hi), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smbrs_proto #(.NREG(NREG), .SLV_ADDR(SLV_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_hi(scl_hi), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .reg_en_i(reg_en_i), .rd_data(rd_data), .sel_idx(sel_idx),
    .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  smbrs_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel_idx(sel_idx), .wr_data(wr_data),
    .reg_en_i(reg_en_i), .rd_data(rd_data), .regs_o(regs_o)
  );
endmodule

// File: tb/smbus_reg_slave_tb.sv
module smbus_reg_slave_tb_top;
  localparam int         NREG = 6;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int         Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG-1:0] reg_en = '1;
  logic [8*NREG-1:0] regs;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int failures = 0;
  int r9_viol = 0;
  logic [7:0] mdl [NREG];

  always #10 clk = ~clk;

  smbus_reg_slave #(.NREG(NREG), .SLV_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .reg_en_i(reg_en), .regs_o(regs)
  );

  // R9 monitor: pull-down must not move while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl === 1'b1) r9_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;   sda_m = 1; scl = 1; wq(Q); sda_m = 0; wq(2*Q); scl = 0; wq(Q); endtask
  task automatic bus_restart; sda_m = 1; wq(Q); scl = 1; wq(Q); sda_m = 0; wq(Q); scl = 0; wq(Q); endtask
  task automatic bus_stop;    sda_m = 0; wq(Q); scl = 1; wq(Q); sda_m = 1; wq(2*Q); endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; wq(Q); scl = 1; wq(Q); ack = (sda_bus == 1'b0); wq(Q); scl = 0; wq(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1; wq(Q); b[i] = sda_bus; wq(Q); scl = 0; wq(Q);
    end
    sda_m = ~mack; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [7:0] d,
                          output bit a0, output bit a1, output bit a2);
    bus_start; send_byte({ADDR, 1'b0}, a0); send_byte(cmd, a1); send_byte(d, a2); bus_stop;
  endtask

  task automatic do_read(input logic [7:0] cmd, input logic [6:0] ra,
                         output bit a0, output bit a1, output bit a2, output logic [7:0] d);
    bus_start; send_byte({ADDR, 1'b0}, a0); send_byte(cmd, a1);
    bus_restart; send_byte({ra, 1'b1}, a2); recv_byte(d, 1'b0); bus_stop;
  endtask

  function automatic logic [8*NREG-1:0] model_flat();
    logic [8*NREG-1:0] f;
    for (int i = 0; i < NREG; i++) f[8*i +: 8] = mdl[i];
    return f;
  endfunction

  task automatic chk_bank(input string req);
    logic [8*NREG-1:0] e;
    e = model_flat();
    chk(regs === e, req, int'(regs), int'(e));
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run;
  end

  initial begin
    bit a0, a1, a2, ax;
    logic [7:0] d;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    wq(5); rst_n = 1; wq(5);

    // R1: reset state
    chk(regs === '0, "R1 regs", int'(regs), 0);
    chk(sda_oe === 1'b0, "R1 sda_oe", int'(sda_oe), 0);

    // R3: full address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      bus_start; send_byte({7'(a), 1'b0}, a0); bus_stop;
      chk(a0 == (a == int'(ADDR)), "R3 addr ack", int'(a0), int'(a == int'(ADDR)));
    end
    // R3: read direction as first byte
    bus_start; send_byte({ADDR, 1'b1}, a0); bus_stop;
    chk(!a0, "R3 read bit first", int'(a0), 0);
    chk_bank("R3 bank");

    // R2 and R4: two patterns into every register, read back
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < NREG; i++) begin
        logic [7:0] v;
        v = 8'((i * 73 + 29) ^ 8'h5A);
        if (pass == 1) v = ~v;
        do_write(8'(i), v, a0, a1, a2);
        mdl[i] = v;
        chk(a0 && a1 && a2, "R2 acks", int'({a0, a1, a2}), 7);
        chk_bank("R2 bank");
      end
      for (int i = 0; i < NREG; i++) begin
        do_read(8'(i), ADDR, a0, a1, a2, d);
        chk(a0 && a1 && a2, "R4 acks", int'({a0, a1, a2}), 7);
        chk(d === mdl[i], "R4 data", int'(d), int'(mdl[i]));
        chk_bank("R4 bank");
      end
    end

    // R3: wrong address after repeated start
    do_read(8'd1, ADDR ^ 7'h01, a0, a1, a2, d);
    chk(!a2, "R3 restart addr", int'(a2), 0);

    // R5: command values outside the bank
    for (int c = NREG; c < NREG + 4; c++) begin
      do_write(8'(c), 8'hA5, a0, a1, a2);
      chk(a0 && !a1, "R5 cmd nack", int'({a0, a1}), 2);
      chk_bank("R5 bank");
    end
    do_write(8'hFF, 8'h3C, a0, a1, a2);
    chk(!a1, "R5 cmd 0xFF", int'(a1), 0);
    chk_bank("R5 bank ff");

    // R6: register 2 blocked
    reg_en = 6'b111011;
    do_write(8'd2, 8'h11, a0, a1, a2);
    chk(!a1, "R6 write nack", int'(a1), 0);
    chk_bank("R6 bank");
    do_read(8'd2, ADDR, a0, a1, a2, d);
    chk(!a1, "R6 read nack", int'(a1), 0);
    do_write(8'd3, 8'h77, a0, a1, a2);
    mdl[3] = 8'h77;
    chk(a1 && a2, "R6 neighbour ok", int'({a1, a2}), 3);
    chk_bank("R6 neighbour bank");
    reg_en = '1;

    // R7: start inside the data byte
    bus_start; send_byte({ADDR, 1'b0}, a0); send_byte(8'd1, a1);
    send_bits(8'h96, 4); bus_restart; bus_stop;
    chk_bank("R7 start abort");
    // R7: stop inside the data byte
    bus_start; send_byte({ADDR, 1'b0}, a0); send_byte(8'd1, a1);
    send_bits(8'h69, 5); bus_stop;
    chk_bank("R7 stop abort");
    // R7: stop inside the command byte
    bus_start; send_byte({ADDR, 1'b0}, a0); send_bits(8'h00, 3); bus_stop;
    chk_bank("R7 cmd abort");
    // R7: recovery
    do_write(8'd1, 8'hC3, a0, a1, a2);
    mdl[1] = 8'hC3;
    chk(a0 && a1 && a2, "R7 recover acks", int'({a0, a1, a2}), 7);
    chk_bank("R7 recover bank");

    // R8: extra byte after data
    bus_start; send_byte({ADDR, 1'b0}, a0); send_byte(8'd4, a1);
    send_byte(8'h5E, a2); send_byte(8'h12, ax); bus_stop;
    chk(a2 && !ax, "R8 extra nack", int'({a2, ax}), 2);
    chk_bank("R8 bank");

    // R9: open-drain timing over the whole run
    chk(r9_viol == 0, "R9 sda scl-low", r9_viol, 0);

    finish_run;
  end
endmodule